// File: doc/BRIEF.md
# Adaptive Cumulative Frequency Model

This block keeps adaptive symbol statistics for a range coder. It holds four independent models. Each model stores, for every symbol of a small alphabet, the symbol's frequency and the cumulative frequency of all lower symbols. A per-model counter tracks the total of all frequencies. When the coder asks about a symbol, the block returns that symbol's frequency, its cumulative base and the model total. It then folds the symbol into the chosen model.

A request is accepted when `busy` is low. The block pulses `done` with the statistics as they stood before the update. It keeps `busy` high while it walks the higher symbols to bump their cumulative bases. If the model total has then reached `LIMIT`, it halves every frequency of that model, rounding up, and rebuilds the cumulative bases and the total in a second walk. `clear` puts every model back to its initial state at the start of a new image cube.

The alphabet size and the model count must be powers of two. The tables sit in on-chip memory arrays that are indexed by model and symbol.

Top module: `freq_model`

## Requirements
- R1: After reset, `busy`, `done`, `sym_freq`, `cum_freq` and `tot_freq` are 0. Every model then holds frequency 1 for each symbol, cumulative base s for symbol s, and total NSYM.
- R2: A request sampled with `req`=1 and `busy`=0 sets `busy` on the next edge. One edge later `done` is high for exactly one cycle. At that point the outputs carry the pre-update frequency of the symbol, the sum of the frequencies of all lower symbols, and the model total.
- R3: After a lookup, the symbol's frequency and the model total each grow by 1, and the cumulative base of every higher symbol grows by 1.
- R4: A request touches only the model selected by `model_id`. The other three models keep their statistics.
- R5: `req` is ignored while `busy` is high. It produces no extra `done` and changes no statistics.
- R6: If the model total is at least `LIMIT` after an update, every frequency f of that model becomes (f+1)/2, rounded down. The cumulative bases and the total are then recomputed from the new frequencies before `busy` falls. A total seen at `done` is therefore always below `LIMIT`.
- R7: No frequency ever drops below 1, including after a rescale.
- R8: A cycle with `clear`=1 aborts any operation and returns all four models to the state given in R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clear | input | 1 | Reinitialise all models (start of cube) |
| req | input | 1 | Lookup-and-update request |
| model_id | input | $clog2(NMODEL) | Model selected by the request |
| sym | input | $clog2(NSYM) | Symbol of the request |
| busy | output | 1 | Operation in progress; requests ignored |
| done | output | 1 | One-cycle pulse, statistics valid |
| sym_freq | output | FW | Frequency of the symbol |
| cum_freq | output | FW | Sum of frequencies of lower symbols |
| tot_freq | output | FW | Model total frequency |

## Verification
A corrupted frequency or cumulative entry shows up at the ports on the next lookup of that model. It appears as a wrong `cum_freq` for every higher symbol and a wrong `tot_freq` for any symbol, so it is visible within one request. A missing or partial bump walk leaves the cumulative bases out of step with the total, and the next `done` on that model exposes it. A faulty rescale shows as a total at or above `LIMIT`, or as halved values that differ from the rounded-up halves, on the first request after the pass. Leaks between models show as soon as an untouched model is queried.

// File: rtl/freq_model.sv
module freq_model #(
  parameter int NMODEL = 4,
  parameter int NSYM   = 16,
  parameter int FW     = 16,
  parameter int LIMIT  = 256,
  localparam int MW = $clog2(NMODEL),
  localparam int SW = $clog2(NSYM),
  localparam int NE = NMODEL * NSYM
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          req,
  input  logic [MW-1:0] model_id,
  input  logic [SW-1:0] sym,
  output logic          busy,
  output logic          done,
  output logic [FW-1:0] sym_freq,
  output logic [FW-1:0] cum_freq,
  output logic [FW-1:0] tot_freq
);

  typedef enum logic [2:0] {S_IDLE, S_LOOK, S_BUMP, S_CHECK, S_HALVE} st_t;

  st_t           state;
  logic [FW-1:0] fq  [NE];
  logic [FW-1:0] cq  [NE];
  logic [FW-1:0] tot [NMODEL];
  logic [MW-1:0] m_q;
  logic [SW-1:0] s_q, idx;
  logic [FW-1:0] run;

  wire [MW+SW-1:0] a_sym  = {m_q, s_q};
  wire [MW+SW-1:0] a_walk = {m_q, idx};
  wire [FW:0]      inc1   = {1'b0, fq[a_walk]} + 1'b1;
  wire [FW-1:0]    half   = inc1[FW:1];
  wire             last   = (idx == SW'(NSYM - 1));

  assign busy = (state != S_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      state <= S_IDLE;
      done  <= 1'b0;
      m_q   <= '0;
      s_q   <= '0;
      idx   <= '0;
      run   <= '0;
      if (!rst_n) begin
        sym_freq <= '0;
        cum_freq <= '0;
        tot_freq <= '0;
      end
      for (int i = 0; i < NE; i++) begin
        fq[i] <= FW'(1);
        cq[i] <= FW'(i % NSYM);
      end
      for (int j = 0; j < NMODEL; j++) tot[j] <= FW'(NSYM);
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: if (req) begin
          m_q   <= model_id;
          s_q   <= sym;
          state <= S_LOOK;
        end
        S_LOOK: begin
          sym_freq    <= fq[a_sym];
          cum_freq    <= cq[a_sym];
          tot_freq    <= tot[m_q];
          done        <= 1'b1;
          fq[a_sym]   <= fq[a_sym] + 1'b1;
          tot[m_q]    <= tot[m_q] + 1'b1;
          idx         <= s_q + 1'b1;
          state       <= (s_q == SW'(NSYM - 1)) ? S_CHECK : S_BUMP;
        end
        S_BUMP: begin
          cq[a_walk] <= cq[a_walk] + 1'b1;
          idx        <= idx + 1'b1;
          if (last) state <= S_CHECK;
        end
        S_CHECK: begin
          idx <= '0;
          run <= '0;
          state <= (tot[m_q] >= FW'(LIMIT)) ? S_HALVE : S_IDLE;
        end
        S_HALVE: begin
          fq[a_walk] <= half;
          cq[a_walk] <= run;
          run        <= run + half;
          idx        <= idx + 1'b1;
          if (last) begin
            tot[m_q] <= run + half;
            state    <= S_IDLE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/freq_model_chk.sv
module freq_model_chk #(
  parameter int FW    = 16,
  parameter int LIMIT = 256
) (
  input logic          clk,
  input logic          rst_n,
  input logic          clear,
  input logic          req,
  input logic          busy,
  input logic          done,
  input logic [FW-1:0] sym_freq,
  input logic [FW-1:0] cum_freq,
  input logic [FW-1:0] tot_freq
);

  a_r2_busy_on_accept: assert property (@(posedge clk) disable iff (!rst_n || clear)
    (req && !busy) |=> busy);

  a_r2_done_single: assert property (@(posedge clk) disable iff (!rst_n || clear)
    done |=> !done);

  a_r5_done_while_busy: assert property (@(posedge clk) disable iff (!rst_n || clear)
    done |-> busy);

  a_r6_total_below_limit: assert property (@(posedge clk) disable iff (!rst_n || clear)
    done |-> (int'(tot_freq) < LIMIT));

  a_r7_freq_positive: assert property (@(posedge clk) disable iff (!rst_n || clear)
    done |-> (sym_freq != '0));

  a_r3_cum_within_total: assert property (@(posedge clk) disable iff (!rst_n || clear)
    done |-> (int'(cum_freq) + int'(sym_freq) <= int'(tot_freq)));

endmodule

bind freq_model freq_model_chk #(.FW(FW), .LIMIT(LIMIT)) u_chk (
  .clk(clk), .rst_n(rst_n), .clear(clear), .req(req), .busy(busy), .done(done),
  .sym_freq(sym_freq), .cum_freq(cum_freq), .tot_freq(tot_freq)
);

// File: tb/freq_model_tb.sv
`timescale 1ns/1ps
module freq_model_tb;
  localparam int NM = 4, NS = 8, FW = 16, LIM = 32;

  logic clk = 0, rst_n = 0, clear = 0, req = 0;
  logic [1:0] model_id = 0;
  logic [2:0] sym = 0;
  logic busy, done;
  logic [FW-1:0] sym_freq, cum_freq, tot_freq;

  int checks = 0, errors = 0;
  int rf [NM][NS];

  always #2 clk = ~clk;

  freq_model #(.NMODEL(NM), .NSYM(NS), .FW(FW), .LIMIT(LIM)) u_dut (
    .clk(clk), .rst_n(rst_n), .clear(clear), .req(req), .model_id(model_id), .sym(sym),
    .busy(busy), .done(done), .sym_freq(sym_freq), .cum_freq(cum_freq), .tot_freq(tot_freq));

  localparam int NV = 16;
  localparam int VM [NV] = '{0,0,1,3,0,2,1,1,3,0,2,2,0,3,1,0};
  localparam int VS [NV] = '{0,7,3,3,4,0,7,7,1,2,5,6,7,0,3,4};

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic ref_init();
    for (int m = 0; m < NM; m++) for (int s = 0; s < NS; s++) rf[m][s] = 1;
  endtask

  function automatic int rcum(int m, int s);
    int c = 0;
    for (int k = 0; k < s; k++) c += rf[m][k];
    return c;
  endfunction

  task automatic ref_update(int m, int s);
    rf[m][s]++;
    if (rcum(m, NS) >= LIM)
      for (int k = 0; k < NS; k++) rf[m][k] = (rf[m][k] + 1) / 2;
  endtask

  task automatic lookup(string tag, int m, int s);
    @(negedge clk);
    while (busy) @(negedge clk);
    req = 1; model_id = 2'(m); sym = 3'(s);
    @(negedge clk);
    req = 0;
    chk({tag, " R2 busy after accept"}, int'(busy), 1);
    @(negedge clk);
    chk({tag, " R2 done timing"}, int'(done), 1);
    chk({tag, " R2 freq"}, int'(sym_freq), rf[m][s]);
    chk({tag, " R2 cum"}, int'(cum_freq), rcum(m, s));
    chk({tag, " R3 total"}, int'(tot_freq), rcum(m, NS));
    ref_update(m, s);
    @(negedge clk);
    chk({tag, " R2 done one cycle"}, int'(done), 0);
    while (busy) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    ref_init();
    repeat (3) @(negedge clk);
    chk("R1 busy", int'(busy), 0);
    chk("R1 done", int'(done), 0);
    chk("R1 outputs", int'(sym_freq) + int'(cum_freq) + int'(tot_freq), 0);
    rst_n = 1;

    lookup("R1 init m1 s5", 1, 5);
    lookup("R1 init m3 s7", 3, 7);

    for (int i = 0; i < NV; i++) lookup("R3 table", VM[i], VS[i]);

    lookup("R4 untouched m2 s1", 2, 1);
    lookup("R4 m3 s2", 3, 2);

    @(negedge clk);
    while (busy) @(negedge clk);
    req = 1; model_id = 0; sym = 3;
    @(negedge clk);
    model_id = 0; sym = 5;
    @(negedge clk);
    req = 0;
    chk("R5 done of accepted", int'(done), 1);
    chk("R5 cum of accepted", int'(cum_freq), rcum(0, 3));
    ref_update(0, 3);
    @(negedge clk);
    chk("R5 no extra done", int'(done), 0);
    while (busy) begin
      chk("R5 no done while walking", int'(done), 0);
      @(negedge clk);
    end
    lookup("R5 ignored symbol unchanged", 0, 5);

    for (int i = 0; i < 40; i++) lookup("R6 rescale run", 2, (i % 3 == 0) ? 6 : 1);
    lookup("R7 rare symbol m2 s0", 2, 0);
    lookup("R7 rare symbol m2 s7", 2, 7);
    lookup("R6 after rescale m2 s4", 2, 4);

    lookup("R8 prep", 1, 2);
    @(negedge clk);
    clear = 1;
    @(negedge clk);
    clear = 0;
    ref_init();
    chk("R8 busy low", int'(busy), 0);
    lookup("R8 m2 s6", 2, 6);
    lookup("R8 m1 s3", 1, 3);
    lookup("R8 m0 s7", 0, 7);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule